// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Disable

This block sits beside a small processor core and turns eighteen request events into interrupts. Three sources have a vector of their own: the external pin, the timer-0 overflow and the timer clock-pin edge. The other fifteen are peripheral sources (port change, three timer overflows, two transmit-empty and two receive-full serial events, the serial-port event, the bus-collision event, converter done and four capture events). They share a single fourth vector. Every source has a flag and an enable. A flag records its event whatever the masks say. The peripheral flags that are enabled are merged into one peripheral-pending signal, and a separate peripheral-gate bit qualifies that signal.

When an enabled request is pending and the global disable bit is clear, the block issues a one-cycle take pulse together with the vector number and the vector address. On the same edge it sets the global disable bit. The core uses that pulse both to push its return address and to load its program counter. Taking a dedicated vector clears that source's flag in hardware. Taking the shared peripheral vector clears no flag, so the handler has to clear the flags itself. A return strobe from the core clears the global disable bit again. A wake-up output reports any enabled pending request, including while interrupts are globally disabled.

Software writes through a four-way select. Select 0 is the control word, select 1 the dedicated flags, select 2 the peripheral enables and select 3 the peripheral flags. `NUM_PERIPH` must be at least 5, because the write data is `NUM_PERIPH` bits wide.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle event on `ded_evt_i[k]` or `per_evt_i[k]` sets the matching flag on the next clock edge, regardless of enables or the global disable bit.
- R2: A write to select 1 (dedicated flags, bits 2:0) or select 3 (peripheral flags) clears every flag whose data bit is 0 and leaves a flag whose data bit is 1 unchanged. A hardware event in the same cycle as a clearing write leaves the flag set.
- R3: While the global disable bit is set, no take pulse is issued. Select 0 bit 4 writes that bit directly.
- R4: A take pulse lasts exactly one cycle. It carries the vector number and that vector's parameter address on `vec_id_o`/`vector_o`, and it sets the global disable bit on the same edge.
- R5: Vector numbers are 0 external pin, 1 timer-0, 2 clock-pin edge and 3 peripheral. When several requests are pending, the lowest number is taken first.
- R6: Taking vector 0, 1 or 2 clears that source's flag, unless a new event for the same source arrives in that same cycle.
- R7: Taking vector 3 clears no flag. A peripheral flag that is still set requests again once the global disable bit is cleared.
- R8: A cycle with `retfie_i` high clears the global disable bit. If a request is being taken in that cycle, the take wins.
- R9: `per_pend_o` is the OR of the peripheral flags ANDed with the select 2 enables. The peripheral vector requests only when select 0 bit 3 (peripheral gate) is also set.
- R10: `wake_o` is high whenever a dedicated flag is pending with its enable set (select 0 bits 0..2, in the vector order of R5), or whenever `per_pend_o` is high with the peripheral gate set. This holds even while the global disable bit is set.
- R11: After reset, all flags, all enables, the global disable bit, the take pulse and the wake-up output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_evt_i | input | 3 | Event pulses for the dedicated sources (bit = vector number) |
| per_evt_i | input | NUM_PERIPH | Event pulses for the peripheral sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 control, 1 dedicated flags, 2 peripheral enables, 3 peripheral flags) |
| wr_data_i | input | NUM_PERIPH | Write data |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle take-interrupt pulse (also the push request) |
| vec_id_o | output | 2 | Number of the vector taken |
| vector_o | output | ADDR_W | Address of the vector taken |
| glb_dis_o | output | 1 | Global disable bit |
| ded_flag_o | output | 3 | Dedicated source flags |
| per_flag_o | output | NUM_PERIPH | Peripheral source flags |
| per_pend_o | output | 1 | Enabled peripheral flag pending |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench keeps the default `NUM_PERIPH` of 15, so the full peripheral set and the full write-data width are in play. It overrides all four vector addresses with distinct values that differ from the defaults. A swapped or mis-indexed address table then shows up on the very first take of each vector. Because `ADDR_W` stays at 16, the scoreboard compares the complete address word and the vector number on every take.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_DED = 3;
    localparam int NUM_VEC = 4;
    localparam int VEC_W   = 2;

    typedef enum logic [VEC_W-1:0] {
        VEC_EXT  = 2'd0,
        VEC_TMR0 = 2'd1,
        VEC_EDGE = 2'd2,
        VEC_PER  = 2'd3
    } vec_id_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DFLAG = 2'd1,
        SEL_PEN   = 2'd2,
        SEL_PFLAG = 2'd3
    } wsel_e;

    // control word layout
    localparam int CTRL_PE   = 3;
    localparam int CTRL_GDIS = 4;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set_i,
    input  logic         sw_we_i,
    input  logic [W-1:0] sw_keep_i,
    input  logic [W-1:0] auto_clr_i,
    output logic [W-1:0] flags_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            if (sw_we_i && !sw_keep_i[i]) st_d.flags[i] = 1'b0;
            if (auto_clr_i[i])            st_d.flags[i] = 1'b0;
            // a fresh event always wins over any clear
            if (hw_set_i[i])              st_d.flags[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        // scan downward so the lowest index is the last one written
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_take_seq.sv
module irq_take_seq
    import irq_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] ADDR_EXT  = 16'h0008,
    parameter logic [ADDR_W-1:0] ADDR_TMR0 = 16'h0010,
    parameter logic [ADDR_W-1:0] ADDR_EDGE = 16'h0018,
    parameter logic [ADDR_W-1:0] ADDR_PER  = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [VEC_W-1:0]  req_idx_i,
    input  logic              retfie_i,
    input  logic              gdis_we_i,
    input  logic              gdis_wval_i,
    output logic              take_now_o,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_id_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic              gdis_o
);

    localparam logic [ADDR_W-1:0] VTAB [NUM_VEC] = '{ADDR_EXT, ADDR_TMR0, ADDR_EDGE, ADDR_PER};

    typedef struct packed {
        logic              take;
        logic [VEC_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              gdis;
    } seq_t;

    seq_t st_d, st_q;
    logic take_now;

    assign take_now = req_valid_i && !st_q.gdis;

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        if (take_now) begin
            st_d.take = 1'b1;
            st_d.idx  = req_idx_i;
            st_d.addr = VTAB[req_idx_i];
            st_d.gdis = 1'b1;
        end else if (retfie_i) begin
            st_d.gdis = 1'b0;
        end else if (gdis_we_i) begin
            st_d.gdis = gdis_wval_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_now_o = take_now;
    assign take_o     = st_q.take;
    assign vec_id_o   = st_q.idx;
    assign vector_o   = st_q.addr;
    assign gdis_o     = st_q.gdis;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int                NUM_PERIPH = 15,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_EXT   = 16'h0008,
    parameter logic [ADDR_W-1:0] ADDR_TMR0  = 16'h0010,
    parameter logic [ADDR_W-1:0] ADDR_EDGE  = 16'h0018,
    parameter logic [ADDR_W-1:0] ADDR_PER   = 16'h0020
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_DED-1:0]    ded_evt_i,
    input  logic [NUM_PERIPH-1:0] per_evt_i,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_sel_i,
    input  logic [NUM_PERIPH-1:0] wr_data_i,
    input  logic                  retfie_i,
    output logic                  take_o,
    output logic [VEC_W-1:0]      vec_id_o,
    output logic [ADDR_W-1:0]     vector_o,
    output logic                  glb_dis_o,
    output logic [NUM_DED-1:0]    ded_flag_o,
    output logic [NUM_PERIPH-1:0] per_flag_o,
    output logic                  per_pend_o,
    output logic                  wake_o
);

    typedef struct packed {
        logic [NUM_DED-1:0]    ded_en;
        logic                  pe;
        logic [NUM_PERIPH-1:0] per_en;
    } en_t;

    en_t en_d, en_q;

    logic [NUM_DED-1:0]    ded_flag, ded_req, ded_clr;
    logic [NUM_PERIPH-1:0] per_flag;
    logic [NUM_VEC-1:0]    vec_req;
    logic                  per_pend, sel_valid, take_now;
    logic [VEC_W-1:0]      sel_idx;
    logic                  wr_ctrl, wr_dflag, wr_pflag;

    assign wr_ctrl  = wr_en_i && (wsel_e'(wr_sel_i) == SEL_CTRL);
    assign wr_dflag = wr_en_i && (wsel_e'(wr_sel_i) == SEL_DFLAG);
    assign wr_pflag = wr_en_i && (wsel_e'(wr_sel_i) == SEL_PFLAG);

    always_comb begin
        en_d = en_q;
        if (wr_ctrl) begin
            en_d.ded_en = wr_data_i[NUM_DED-1:0];
            en_d.pe     = wr_data_i[CTRL_PE];
        end
        if (wr_en_i && (wsel_e'(wr_sel_i) == SEL_PEN)) begin
            en_d.per_en = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // hardware clear only for the dedicated vector being taken
    always_comb begin
        ded_clr = '0;
        if (take_now && (vec_id_e'(sel_idx) != VEC_PER)) begin
            ded_clr = NUM_DED'(1) << sel_idx;
        end
    end

    irq_flag_bank #(.W(NUM_DED)) u_ded_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set_i   (ded_evt_i),
        .sw_we_i    (wr_dflag),
        .sw_keep_i  (wr_data_i[NUM_DED-1:0]),
        .auto_clr_i (ded_clr),
        .flags_o    (ded_flag)
    );

    irq_flag_bank #(.W(NUM_PERIPH)) u_per_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set_i   (per_evt_i),
        .sw_we_i    (wr_pflag),
        .sw_keep_i  (wr_data_i),
        .auto_clr_i ('0),
        .flags_o    (per_flag)
    );

    assign ded_req  = ded_flag & en_q.ded_en;
    assign per_pend = |(per_flag & en_q.per_en);

    generate
        for (genvar g = 0; g < NUM_DED; g++) begin : g_ded_req
            assign vec_req[g] = ded_req[g];
        end
    endgenerate
    assign vec_req[VEC_PER] = per_pend && en_q.pe;

    irq_prio_sel #(.N(NUM_VEC)) u_prio (
        .req_i   (vec_req),
        .valid_o (sel_valid),
        .idx_o   (sel_idx)
    );

    irq_take_seq #(
        .ADDR_W    (ADDR_W),
        .ADDR_EXT  (ADDR_EXT),
        .ADDR_TMR0 (ADDR_TMR0),
        .ADDR_EDGE (ADDR_EDGE),
        .ADDR_PER  (ADDR_PER)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (sel_valid),
        .req_idx_i   (sel_idx),
        .retfie_i    (retfie_i),
        .gdis_we_i   (wr_ctrl),
        .gdis_wval_i (wr_data_i[CTRL_GDIS]),
        .take_now_o  (take_now),
        .take_o      (take_o),
        .vec_id_o    (vec_id_o),
        .vector_o    (vector_o),
        .gdis_o      (glb_dis_o)
    );

    assign ded_flag_o = ded_flag;
    assign per_flag_o = per_flag;
    assign per_pend_o = per_pend;
    assign wake_o     = (|vec_req);

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int NUM_PERIPH = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            ded_evt_i,
    input logic [NUM_PERIPH-1:0] per_evt_i,
    input logic                  wr_en_i,
    input logic                  retfie_i,
    input logic                  take_o,
    input logic [1:0]            vec_id_o,
    input logic                  glb_dis_o,
    input logic [2:0]            ded_flag_o,
    input logic [NUM_PERIPH-1:0] per_flag_o,
    input logic                  per_pend_o,
    input logic                  wake_o
);

    logic [2:0] id_mask;
    assign id_mask = 3'(3'b001 << vec_id_o);

    assert_per_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (per_evt_i != '0) |=> ((per_flag_o & $past(per_evt_i)) == $past(per_evt_i)));

    assert_ded_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ded_evt_i != '0) |=> ((ded_flag_o & $past(ded_evt_i)) == $past(ded_evt_i)));

    assert_gdis_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        glb_dis_o |=> !take_o);

    assert_take_sets_gdis_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> glb_dis_o);

    assert_take_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_ded_autoclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (vec_id_o != 2'd3) && ((id_mask & $past(ded_evt_i)) == '0))
        |-> ((id_mask & ded_flag_o) == '0));

    assert_per_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (vec_id_o == 2'd3) && !$past(wr_en_i))
        |-> (($past(per_flag_o) & ~per_flag_o) == '0));

    assert_ret_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retfie_i && glb_dis_o) |=> !glb_dis_o);

    assert_pend_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        per_pend_o |-> (per_flag_o != '0));

    assert_wake_before_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(wake_o));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ded_evt_i  (ded_evt_i),
    .per_evt_i  (per_evt_i),
    .wr_en_i    (wr_en_i),
    .retfie_i   (retfie_i),
    .take_o     (take_o),
    .vec_id_o   (vec_id_o),
    .glb_dis_o  (glb_dis_o),
    .ded_flag_o (ded_flag_o),
    .per_flag_o (per_flag_o),
    .per_pend_o (per_pend_o),
    .wake_o     (wake_o)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;

    localparam int NP = 15;
    localparam int AW = 16;
    localparam logic [AW-1:0] A_EXT  = 16'h0A08;
    localparam logic [AW-1:0] A_TMR0 = 16'h0B10;
    localparam logic [AW-1:0] A_EDGE = 16'h0C18;
    localparam logic [AW-1:0] A_PER  = 16'h0D20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    ded_evt_i = '0;
    logic [NP-1:0] per_evt_i = '0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_sel_i = '0;
    logic [NP-1:0] wr_data_i = '0;
    logic          retfie_i = 1'b0;
    logic          take_o;
    logic [1:0]    vec_id_o;
    logic [AW-1:0] vector_o;
    logic          glb_dis_o;
    logic [2:0]    ded_flag_o;
    logic [NP-1:0] per_flag_o;
    logic          per_pend_o;
    logic          wake_o;

    always #10 clk = ~clk;

    irq_vector_ctrl #(
        .NUM_PERIPH (NP), .ADDR_W (AW),
        .ADDR_EXT (A_EXT), .ADDR_TMR0 (A_TMR0), .ADDR_EDGE (A_EDGE), .ADDR_PER (A_PER)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ded_evt_i (ded_evt_i), .per_evt_i (per_evt_i),
        .wr_en_i (wr_en_i), .wr_sel_i (wr_sel_i), .wr_data_i (wr_data_i),
        .retfie_i (retfie_i), .take_o (take_o), .vec_id_o (vec_id_o),
        .vector_o (vector_o), .glb_dis_o (glb_dis_o), .ded_flag_o (ded_flag_o),
        .per_flag_o (per_flag_o), .per_pend_o (per_pend_o), .wake_o (wake_o)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int exp_q[$];
    bit prev_take = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int id);
        case (id)
            0:       return A_EXT;
            1:       return A_TMR0;
            2:       return A_EDGE;
            default: return A_PER;
        endcase
    endfunction

    // driver side of the scoreboard
    task automatic expect_take(input int id);
        exp_q.push_back(id);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (take_o) begin
                chk(!prev_take, "R4", "take pulse width", 32'(prev_take), 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected take, vec", 32'(vec_id_o), 32'hFFFF);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(vec_id_o == 2'(e), "R5", "vector number", 32'(vec_id_o), 32'(e));
                    chk(vector_o == addr_of(e), "R4", "vector address", 32'(vector_o), 32'(addr_of(e)));
                end
            end
            prev_take = take_o;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [NP-1:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        step(1);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic pulse(input logic [2:0] d, input logic [NP-1:0] p);
        ded_evt_i = d; per_evt_i = p;
        step(1);
        ded_evt_i = '0; per_evt_i = '0;
    endtask

    task automatic ret();
        retfie_i = 1'b1;
        step(1);
        retfie_i = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R11: reset state
        at_neg();
        chk(ded_flag_o == '0, "R11", "ded flags", 32'(ded_flag_o), 0);
        chk(per_flag_o == '0, "R11", "per flags", 32'(per_flag_o), 0);
        chk(!glb_dis_o, "R11", "global disable", 32'(glb_dis_o), 0);
        chk(!take_o && !wake_o, "R11", "take/wake", {30'd0, take_o, wake_o}, 0);

        // R1: flags set with every mask clear
        step(0);
        pulse(3'b111, 15'h0088);
        at_neg();
        chk(ded_flag_o == 3'b111, "R1", "ded flags", 32'(ded_flag_o), 7);
        chk(per_flag_o == 15'h0088, "R1", "per flags", 32'(per_flag_o), 32'h88);
        step(3);
        at_neg();
        chk(!wake_o, "R10", "wake with enables off", 32'(wake_o), 0);

        // R2: write-zero clears, write-one keeps, hardware set wins
        step(0);
        reg_write(2'd1, 15'h0006);
        at_neg();
        chk(ded_flag_o == 3'b110, "R2", "ded flag clear bit0", 32'(ded_flag_o), 6);
        step(0);
        reg_write(2'd3, '1);
        at_neg();
        chk(per_flag_o == 15'h0088, "R2", "write ones keeps", 32'(per_flag_o), 32'h88);
        step(0);
        per_evt_i = 15'h0020;
        reg_write(2'd3, '0);
        per_evt_i = '0;
        at_neg();
        chk(per_flag_o == 15'h0020, "R2", "hw set beats clear", 32'(per_flag_o), 32'h20);
        step(0);
        reg_write(2'd1, '0);
        reg_write(2'd3, '0);
        at_neg();
        chk(ded_flag_o == '0 && per_flag_o == '0, "R2", "all cleared",
            32'({ded_flag_o, per_flag_o}), 0);

        // R3, R10, R8, R6: blocked by global disable, then released
        step(0);
        reg_write(2'd0, 15'h0011);
        at_neg();
        chk(glb_dis_o, "R3", "disable written", 32'(glb_dis_o), 1);
        step(0);
        pulse(3'b001, '0);
        step(3);
        at_neg();
        chk(wake_o, "R10", "wake while disabled", 32'(wake_o), 1);
        chk(ded_flag_o == 3'b001, "R3", "flag waits", 32'(ded_flag_o), 1);
        step(0);
        expect_take(0);
        ret();
        step(1);
        at_neg();
        chk(glb_dis_o, "R4", "disable set by take", 32'(glb_dis_o), 1);
        chk(ded_flag_o == '0, "R6", "ext flag auto-cleared", 32'(ded_flag_o), 0);

        // R5, R7: priority and the shared vector
        step(0);
        reg_write(2'd0, 15'h001F);
        reg_write(2'd2, 15'h0001);
        pulse(3'b111, 15'h0001);
        step(2);
        expect_take(0); ret(); step(2);
        expect_take(1); ret(); step(2);
        expect_take(2); ret(); step(2);
        expect_take(3); ret(); step(2);
        at_neg();
        chk(per_flag_o == 15'h0001, "R7", "per flag kept", 32'(per_flag_o), 1);
        chk(ded_flag_o == '0, "R6", "ded flags cleared", 32'(ded_flag_o), 0);
        step(0);
        expect_take(3); ret(); step(2);
        reg_write(2'd3, '0);
        ret();
        step(3);
        at_neg();
        chk(!glb_dis_o, "R8", "return clears disable", 32'(glb_dis_o), 0);
        chk(exp_q.size() == 0, "R7", "re-request count", 32'(exp_q.size()), 0);

        // R9: peripheral pending and its gate
        step(0);
        reg_write(2'd0, '0);
        reg_write(2'd2, 15'h0004);
        pulse('0, 15'h0080);
        at_neg();
        chk(!per_pend_o, "R9", "masked flag not pending", 32'(per_pend_o), 0);
        step(0);
        pulse('0, 15'h0004);
        at_neg();
        chk(per_pend_o, "R9", "enabled flag pending", 32'(per_pend_o), 1);
        chk(!wake_o, "R10", "wake needs gate", 32'(wake_o), 0);
        step(2);
        expect_take(3);
        reg_write(2'd0, 15'h0008);
        step(1);
        at_neg();
        chk(glb_dis_o, "R9", "gate opens take", 32'(glb_dis_o), 1);
        step(0);
        reg_write(2'd3, '0);
        ret();
        step(2);
        at_neg();
        chk(!per_pend_o && !glb_dis_o, "R8", "idle after return",
            {30'd0, per_pend_o, glb_dis_o}, 0);

        // R6: a new event in the take cycle keeps the flag
        step(0);
        reg_write(2'd0, 15'h0002);
        expect_take(1);
        ded_evt_i = 3'b010;
        step(2);
        ded_evt_i = '0;
        at_neg();
        chk(ded_flag_o == 3'b010, "R6", "hw set beats auto-clear", 32'(ded_flag_o), 2);
        step(0);
        expect_take(1);
        ret();
        step(2);
        at_neg();
        chk(ded_flag_o == '0, "R6", "second take clears", 32'(ded_flag_o), 0);
        step(3);
        at_neg();
        chk(exp_q.size() == 0, "R4", "scoreboard drained", 32'(exp_q.size()), 0);

        done = 1'b1;
        summary();
    end

endmodule